// File: doc/BRIEF.md
# Precision-Time Event Timestamp Queue

This block records when timing-protocol event messages cross one direction of a port. A parser upstream presents each message's type, domain and sequence identifier together with a one-cycle strobe. The block samples the free-running 64-bit time base in that same cycle. It keeps the message only if the configured per-type enable bit is set. It adds a configured signed offset to the sampled time and appends the result to a small first-in first-out store. One instance serves receive and a second instance serves transmit. Each instance has its own enable mask and its own offset.

Time values count ticks of the time-base clock, which runs at 156.25 MHz, so one tick is 6.4 ns. A record enters the store before its packet reaches software. Software pairs the two by sequence identifier. To fetch records, software issues a read request. The response arrives one cycle later and carries up to four records in a batch, with the oldest record in slot 0, plus a count of the valid slots. The returned records leave the store. A clear operation empties the store. If the store is full, any further message is dropped and a sticky overflow flag is raised.

Top module: `ptp_tsfifo`

## Requirements
- R1: After reset the enable mask is all zeros and the offset is zero, so no message is stored. Reset also drives the response valid to 0, the response count to 0 and overflow to 0.
- R2: Writing the configuration with cfg_we loads the mask and the offset. A strobed message is stored only when mask bit number msg_type is 1. Bit 0 corresponds to type 0 (Sync) and bit 1 to type 1 (Delay_Req).
- R3: A stored record keeps the 4-bit type, 8-bit domain and 16-bit sequence identifier as presented. Its timestamp is time_now in the strobe cycle plus the offset, modulo 2^64, and the carry propagates across the 32-bit boundary. The response presents the timestamp as bits 63:32 on the high word and bits 31:0 on the low word.
- R4: The offset is 32-bit two's complement and is sign-extended before the addition, so a negative offset subtracts and wraps below zero.
- R5: A read request gives rsp_valid high for exactly the next cycle. The response count equals min(stored, 4). Records come out in arrival order with the oldest in slot 0 (bits [3:0] / [15:0] / [31:0] of the slot vectors), and the returned records are removed.
- R6: Every slot at or above the response count reads as zero in all fields.
- R7: When 16 records are stored, a new accepted message is dropped, the existing records are kept, and overflow goes high. Overflow stays high until a clear.
- R8: A clear empties the store and lowers overflow. If a read request or a message arrives in the same cycle as a clear, it is ignored: no response is given and nothing is stored.
- R9: A message accepted in the same cycle as a read request is stored behind the records that read returns, and it appears in a later read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Load mask and offset |
| cfg_mask | input | 16 | Per-message-type enable, bit n for type n |
| cfg_adj | input | 32 | Signed timestamp offset |
| cap_valid | input | 1 | Parsed message strobe |
| cap_type | input | 4 | Message type |
| cap_domain | input | 8 | Domain number |
| cap_seq | input | 16 | Sequence identifier |
| time_now | input | 64 | Current time in ticks |
| rd_req | input | 1 | Fetch a batch |
| rd_clr | input | 1 | Empty the store and clear overflow |
| rsp_valid | output | 1 | Batch response present |
| rsp_count | output | 4 | Number of valid slots |
| rsp_type | output | 16 | Slot types, 4 bits per slot |
| rsp_domain | output | 32 | Slot domains, 8 bits per slot |
| rsp_seq | output | 64 | Slot sequence identifiers, 16 bits per slot |
| rsp_ts_hi | output | 128 | Slot timestamp bits 63:32 |
| rsp_ts_lo | output | 128 | Slot timestamp bits 31:0 |
| overflow | output | 1 | Sticky drop indicator |

## Verification
The filter is tested three ways: with a mask holding only the Delay_Req bit and a mix of Sync, Delay_Req and other types; with an all-zero mask after reset; and with an all-ones mask. Together these show that the correct bit position selects a message and that the mask is not ignored. Positive offsets are chosen to carry across the 32-bit word boundary and negative offsets to borrow across it or wrap below zero, so a missing sign extension or a dropped carry appears in the high word. Batches of three, six and seventeen messages exercise partial reads, multi-read ordering and the full-store drop. Same-cycle combinations of message, read and clear settle which action takes precedence.

// File: rtl/ptp_tsfifo_pkg.sv
package ptp_tsfifo_pkg;
    localparam int TYPE_W = 4;
    localparam int DOM_W  = 8;
    localparam int SEQ_W  = 16;
    localparam int TS_W   = 64;
    localparam int MASK_W = 1 << TYPE_W;

    typedef struct packed {
        logic [TYPE_W-1:0] msg_type;
        logic [DOM_W-1:0]  domain;
        logic [SEQ_W-1:0]  seq_id;
        logic [TS_W-1:0]   stamp;
    } ts_rec_t;
endpackage

// File: rtl/ptp_tsf_filter.sv
module ptp_tsf_filter
    import ptp_tsfifo_pkg::*;
#(
    parameter int ADJ_W = 32
) (
    input  logic              in_valid,
    input  logic [TYPE_W-1:0] in_type,
    input  logic [MASK_W-1:0] type_mask,
    input  logic [ADJ_W-1:0]  adj,
    input  logic [TS_W-1:0]   time_now,
    output logic              hit,
    output logic [TS_W-1:0]   stamp
);
    logic [TS_W-1:0] adj_ext;

    always_comb begin
        hit     = in_valid & type_mask[in_type];
        adj_ext = {{(TS_W-ADJ_W){adj[ADJ_W-1]}}, adj};
        stamp   = time_now + adj_ext;
    end
endmodule

// File: rtl/ptp_tsf_store.sv
module ptp_tsf_store
    import ptp_tsfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int BATCH = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int CNT_W = $clog2(BATCH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   push,
    input  ts_rec_t                push_rec,
    input  logic [CNT_W-1:0]       pop_cnt,
    output logic [LVL_W-1:0]       level,
    output ts_rec_t [BATCH-1:0]    head
);
    typedef struct packed {
        logic [AW-1:0]    wr;
        logic [AW-1:0]    rd;
        logic [LVL_W-1:0] lvl;
    } ptr_t;

    ptr_t    ptr_d, ptr_q;
    ts_rec_t mem_q [DEPTH];

    always_comb begin
        ptr_d = ptr_q;
        if (clr) begin
            ptr_d = '0;
        end else begin
            ptr_d.wr  = ptr_q.wr + AW'(push);
            ptr_d.rd  = ptr_q.rd + AW'(pop_cnt);
            ptr_d.lvl = ptr_q.lvl + LVL_W'(push) - LVL_W'(pop_cnt);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (push && !clr) mem_q[ptr_q.wr] <= push_rec;
    end

    assign level = ptr_q.lvl;

    for (genvar i = 0; i < BATCH; i++) begin : g_head
        assign head[i] = mem_q[ptr_q.rd + AW'(i)];
    end
endmodule

// File: rtl/ptp_tsfifo.sv
module ptp_tsfifo
    import ptp_tsfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int BATCH = 4,
    parameter int ADJ_W = 32,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int CNT_W = $clog2(BATCH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [MASK_W-1:0]        cfg_mask,
    input  logic [ADJ_W-1:0]         cfg_adj,
    input  logic                     cap_valid,
    input  logic [TYPE_W-1:0]        cap_type,
    input  logic [DOM_W-1:0]         cap_domain,
    input  logic [SEQ_W-1:0]         cap_seq,
    input  logic [TS_W-1:0]          time_now,
    input  logic                     rd_req,
    input  logic                     rd_clr,
    output logic                     rsp_valid,
    output logic [3:0]               rsp_count,
    output logic [BATCH*TYPE_W-1:0]  rsp_type,
    output logic [BATCH*DOM_W-1:0]   rsp_domain,
    output logic [BATCH*SEQ_W-1:0]   rsp_seq,
    output logic [BATCH*32-1:0]      rsp_ts_hi,
    output logic [BATCH*32-1:0]      rsp_ts_lo,
    output logic                     overflow
);
    typedef struct packed {
        logic [MASK_W-1:0]   mask;
        logic [ADJ_W-1:0]    adj;
        logic                ovf;
        logic                rsp_v;
        logic [3:0]          rsp_n;
        ts_rec_t [BATCH-1:0] rsp;
    } st_t;

    st_t                 st_d, st_q;
    logic                hit;
    logic [TS_W-1:0]     stamp;
    logic                full;
    logic                push;
    logic [CNT_W-1:0]    take;
    logic [LVL_W-1:0]    level;
    ts_rec_t             new_rec;
    ts_rec_t [BATCH-1:0] head;

    ptp_tsf_filter #(.ADJ_W(ADJ_W)) u_filter (
        .in_valid  (cap_valid),
        .in_type   (cap_type),
        .type_mask (st_q.mask),
        .adj       (st_q.adj),
        .time_now  (time_now),
        .hit       (hit),
        .stamp     (stamp)
    );

    ptp_tsf_store #(.DEPTH(DEPTH), .BATCH(BATCH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (rd_clr),
        .push     (push),
        .push_rec (new_rec),
        .pop_cnt  (take),
        .level    (level),
        .head     (head)
    );

    always_comb begin
        new_rec = '{msg_type: cap_type, domain: cap_domain, seq_id: cap_seq, stamp: stamp};
        full    = (level == LVL_W'(DEPTH));
        push    = hit && !full && !rd_clr;
        take    = '0;
        if (rd_req && !rd_clr)
            take = (level >= LVL_W'(BATCH)) ? CNT_W'(BATCH) : CNT_W'(level);

        st_d       = st_q;
        st_d.rsp_v = rd_req && !rd_clr;
        if (cfg_we) begin
            st_d.mask = cfg_mask;
            st_d.adj  = cfg_adj;
        end
        if (rd_clr)            st_d.ovf = 1'b0;
        else if (hit && full)  st_d.ovf = 1'b1;
        if (rd_req && !rd_clr) begin
            st_d.rsp_n = 4'(take);
            for (int i = 0; i < BATCH; i++)
                st_d.rsp[i] = (CNT_W'(i) < take) ? head[i] : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_v;
    assign rsp_count = st_q.rsp_n;
    assign overflow  = st_q.ovf;

    for (genvar i = 0; i < BATCH; i++) begin : g_slot
        assign rsp_type[i*TYPE_W +: TYPE_W] = st_q.rsp[i].msg_type;
        assign rsp_domain[i*DOM_W +: DOM_W] = st_q.rsp[i].domain;
        assign rsp_seq[i*SEQ_W +: SEQ_W]    = st_q.rsp[i].seq_id;
        assign rsp_ts_hi[i*32 +: 32]        = st_q.rsp[i].stamp[63:32];
        assign rsp_ts_lo[i*32 +: 32]        = st_q.rsp[i].stamp[31:0];
    end
endmodule

// File: rtl/ptp_tsfifo_chk.sv
module ptp_tsfifo_chk #(
    parameter int BATCH = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rd_req,
    input logic                 rd_clr,
    input logic                 cap_valid,
    input logic                 rsp_valid,
    input logic [3:0]           rsp_count,
    input logic [BATCH*4-1:0]   rsp_type,
    input logic [BATCH*16-1:0]  rsp_seq,
    input logic                 overflow
);
    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_clr |=> rsp_valid); // R5
    AST_RSP_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rsp_valid); // R5
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_count <= 4'(BATCH)); // R5
    AST_EMPTY_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_count == 4'd0 |-> rsp_type == '0 && rsp_seq == '0); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !rd_clr |=> overflow); // R7
    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(cap_valid)); // R7
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> !overflow && !rsp_valid); // R8
endmodule

bind ptp_tsfifo ptp_tsfifo_chk #(.BATCH(BATCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .rd_clr    (rd_clr),
    .cap_valid (cap_valid),
    .rsp_valid (rsp_valid),
    .rsp_count (rsp_count),
    .rsp_type  (rsp_type),
    .rsp_seq   (rsp_seq),
    .overflow  (overflow)
);

// File: tb/ptp_tsfifo_tb.sv
module ptp_tsfifo_tb;
    localparam time CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [15:0]  cfg_mask = '0;
    logic [31:0]  cfg_adj = '0;
    logic         cap_valid = 1'b0;
    logic [3:0]   cap_type = '0;
    logic [7:0]   cap_domain = '0;
    logic [15:0]  cap_seq = '0;
    logic [63:0]  time_now = '0;
    logic         rd_req = 1'b0;
    logic         rd_clr = 1'b0;
    logic         rsp_valid;
    logic [3:0]   rsp_count;
    logic [15:0]  rsp_type;
    logic [31:0]  rsp_domain;
    logic [63:0]  rsp_seq;
    logic [127:0] rsp_ts_hi;
    logic [127:0] rsp_ts_lo;
    logic         overflow;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptp_tsfifo u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mask(cfg_mask), .cfg_adj(cfg_adj),
        .cap_valid(cap_valid), .cap_type(cap_type), .cap_domain(cap_domain), .cap_seq(cap_seq),
        .time_now(time_now), .rd_req(rd_req), .rd_clr(rd_clr), .rsp_valid(rsp_valid),
        .rsp_count(rsp_count), .rsp_type(rsp_type), .rsp_domain(rsp_domain), .rsp_seq(rsp_seq),
        .rsp_ts_hi(rsp_ts_hi), .rsp_ts_lo(rsp_ts_lo), .overflow(overflow)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic chk_slot(input string tag, input int i, input logic [3:0] t,
                            input logic [7:0] d, input logic [15:0] s, input logic [63:0] ts);
        chk({tag, " type"},   64'(rsp_type[i*4 +: 4]),    64'(t));
        chk({tag, " domain"}, 64'(rsp_domain[i*8 +: 8]),  64'(d));
        chk({tag, " seq"},    64'(rsp_seq[i*16 +: 16]),   64'(s));
        chk({tag, " ts_hi"},  64'(rsp_ts_hi[i*32 +: 32]), 64'(ts[63:32]));
        chk({tag, " ts_lo"},  64'(rsp_ts_lo[i*32 +: 32]), 64'(ts[31:0]));
    endtask

    task automatic do_cfg(input logic [15:0] m, input logic [31:0] a);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mask = m; cfg_adj = a;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_cap(input logic [3:0] t, input logic [7:0] d,
                           input logic [15:0] s, input logic [63:0] now);
        cap_valid = 1'b1; cap_type = t; cap_domain = d; cap_seq = s; time_now = now;
    endtask

    task automatic do_cap(input logic [3:0] t, input logic [7:0] d,
                          input logic [15:0] s, input logic [63:0] now);
        @(negedge clk);
        set_cap(t, d, s, now);
        @(negedge clk);
        cap_valid = 1'b0;
    endtask

    task automatic do_read();
        @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        rd_clr = 1'b1;
        @(negedge clk);
        rd_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        chk("R1 rsp_count after reset", 64'(rsp_count), 64'd0);
        chk("R1 overflow after reset",  64'(overflow),  64'd0);
        do_cap(4'd0, 8'd1, 16'h0101, 64'd50);
        do_cap(4'd1, 8'd1, 16'h0102, 64'd51);
        do_read();
        chk("R1 zero mask stores nothing", 64'(rsp_count), 64'd0);
    endtask

    task automatic t_filter();
        do_cfg(16'h0002, 32'd0);
        do_cap(4'd0, 8'd2, 16'h0200, 64'd10);
        do_cap(4'd1, 8'd2, 16'h0201, 64'd11);
        do_cap(4'd3, 8'd2, 16'h0202, 64'd12);
        do_read();
        chk("R2 only Delay_Req kept", 64'(rsp_count), 64'd1);
        chk_slot("R2 slot0", 0, 4'd1, 8'd2, 16'h0201, 64'd11);
    endtask

    task automatic t_fields();
        do_cfg(16'hFFFF, 32'd100);
        do_cap(4'd0,  8'h11, 16'hA001, 64'h0000_0001_FFFF_FFF0);
        do_cap(4'd9,  8'h22, 16'hA002, 64'h0000_0000_0000_0005);
        do_cap(4'd15, 8'hFF, 16'hFFFF, 64'h1234_5678_0000_0000);
        do_read();
        chk("R5 partial batch count", 64'(rsp_count), 64'd3);
        chk("R5 rsp_valid", 64'(rsp_valid), 64'd1);
        chk_slot("R3 slot0 carry", 0, 4'd0,  8'h11, 16'hA001, 64'h0000_0002_0000_0054);
        chk_slot("R3 slot1",       1, 4'd9,  8'h22, 16'hA002, 64'd105);
        chk_slot("R3 slot2",       2, 4'd15, 8'hFF, 16'hFFFF, 64'h1234_5678_0000_0064);
        chk_slot("R6 slot3 zero",  3, 4'd0,  8'd0,  16'd0,    64'd0);
        @(negedge clk);
        chk("R5 valid lasts one cycle", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_negadj();
        do_cfg(16'hFFFF, 32'hFFFF_FFFB);
        do_cap(4'd2, 8'd3, 16'h0301, 64'd3);
        do_cap(4'd2, 8'd3, 16'h0302, 64'h0000_0001_0000_0002);
        do_read();
        chk("R4 count", 64'(rsp_count), 64'd2);
        chk_slot("R4 wrap below zero", 0, 4'd2, 8'd3, 16'h0301, 64'hFFFF_FFFF_FFFF_FFFE);
        chk_slot("R4 borrow",          1, 4'd2, 8'd3, 16'h0302, 64'h0000_0000_FFFF_FFFD);
    endtask

    task automatic t_batch();
        do_cfg(16'hFFFF, 32'd0);
        for (int k = 0; k < 6; k++) do_cap(4'd0, 8'd4, 16'(16'h0400 + k), 64'(1000 + k));
        do_read();
        chk("R5 first batch count", 64'(rsp_count), 64'd4);
        for (int k = 0; k < 4; k++)
            chk("R5 first batch order", 64'(rsp_seq[k*16 +: 16]), 64'(16'h0400 + k));
        do_read();
        chk("R5 second batch count", 64'(rsp_count), 64'd2);
        chk_slot("R5 second slot0", 0, 4'd0, 8'd4, 16'h0404, 64'd1004);
        chk_slot("R5 second slot1", 1, 4'd0, 8'd4, 16'h0405, 64'd1005);
        chk_slot("R6 second slot2", 2, 4'd0, 8'd0, 16'd0, 64'd0);
        do_read();
        chk("R5 drained", 64'(rsp_count), 64'd0);
    endtask

    task automatic t_simul();
        do_cap(4'd1, 8'd5, 16'h0501, 64'd1);
        do_cap(4'd1, 8'd5, 16'h0502, 64'd2);
        @(negedge clk);
        set_cap(4'd1, 8'd5, 16'h0503, 64'd3);
        rd_req = 1'b1;
        @(negedge clk);
        cap_valid = 1'b0; rd_req = 1'b0;
        chk("R9 read excludes same-cycle capture", 64'(rsp_count), 64'd2);
        chk("R9 slot0", 64'(rsp_seq[15:0]), 64'h0501);
        chk("R9 slot1", 64'(rsp_seq[31:16]), 64'h0502);
        do_read();
        chk("R9 later read count", 64'(rsp_count), 64'd1);
        chk_slot("R9 later slot0", 0, 4'd1, 8'd5, 16'h0503, 64'd3);
    endtask

    task automatic t_overflow();
        for (int k = 0; k < 16; k++) do_cap(4'd0, 8'd6, 16'(k), 64'(k));
        chk("R7 no overflow at exactly full", 64'(overflow), 64'd0);
        do_cap(4'd0, 8'd6, 16'h00EE, 64'd99);
        chk("R7 overflow set", 64'(overflow), 64'd1);
        for (int b = 0; b < 4; b++) begin
            do_read();
            chk("R7 full batch", 64'(rsp_count), 64'd4);
            for (int k = 0; k < 4; k++)
                chk("R7 kept records in order", 64'(rsp_seq[k*16 +: 16]), 64'(b*4 + k));
        end
        do_read();
        chk("R7 dropped record absent", 64'(rsp_count), 64'd0);
        chk("R7 overflow sticky", 64'(overflow), 64'd1);
        do_clear();
        chk("R8 clear lowers overflow", 64'(overflow), 64'd0);
    endtask

    task automatic t_clear();
        for (int k = 0; k < 3; k++) do_cap(4'd0, 8'd7, 16'(16'h0700 + k), 64'(k));
        @(negedge clk);
        set_cap(4'd0, 8'd7, 16'h07FF, 64'd9);
        rd_req = 1'b1; rd_clr = 1'b1;
        @(negedge clk);
        cap_valid = 1'b0; rd_req = 1'b0; rd_clr = 1'b0;
        chk("R8 read ignored during clear", 64'(rsp_valid), 64'd0);
        do_read();
        chk("R8 store empty after clear", 64'(rsp_count), 64'd0);
        do_cap(4'd0, 8'd7, 16'h0777, 64'd20);
        do_read();
        chk("R8 capture works after clear", 64'(rsp_count), 64'd1);
        chk("R8 fresh record", 64'(rsp_seq[15:0]), 64'h0777);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_filter();
        t_fields();
        t_negadj();
        t_batch();
        t_simul();
        t_overflow();
        t_clear();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule